// File: doc/BRIEF.md
# Variable-Width Flash Data Register Port

This block is the data register that a host bus sees on a serial flash controller. Behind it sits a byte-wide FIFO. A host access moves one, two or four bytes, depending on its size field. An indirect write pushes the bytes of the access into the FIFO, and the flash engine drains them one byte at a time. An indirect read pops bytes that the flash engine has pushed. When the FIFO cannot serve the whole access, the port stalls the host by holding `host_ready_o` low.

A read stall ends in one of two ways: enough bytes arrive, or the flash engine signals that the transfer is finished. When the transfer finishes first, the read takes the bytes that are present and puts zeros in the empty lanes. In polling mode the FIFO is left alone. A capture strobe from the flash engine loads a 32-bit status word, and host reads return that word as it was captured, with no masking.

Bytes are packed little-endian: the first byte in the FIFO order occupies bits 7:0, the next occupies bits 15:8, and so on. The FIFO depth must be a power of two. Mode encoding is 0 = indirect write, 1 = indirect read, 2 = polling, 3 = idle. Size encoding is 0 = byte, 1 = halfword, 2 or 3 = word.

Top module: `flash_data_port`

## Requirements
- R1: After reset the FIFO level is 0, `fl_pop_valid_o` is low, and a polling-mode read returns 0x00000000.
- R2: In write mode, an accepted host write pushes 1, 2 or 4 bytes for size 0, 1 or 2. The bytes are taken little-endian from the bottom of `host_wdata_i` and leave on `fl_pop_data_o` in that order.
- R3: In write mode, a host write keeps `host_ready_o` low until the FIFO has free space for every byte of the access.
- R4: In read mode, an accepted host read pops 1, 2 or 4 bytes. The bytes are returned little-endian from bit 0 upward, and the lanes above the access size read as zero.
- R5: In read mode, while `busy_i` is high and the level is below the access size, a read stalls. It completes once enough bytes are present and then returns all of them.
- R6: When `xfer_done_i` is high during a stalled read, the read completes in that cycle. It pops only the bytes present and returns zero in the missing lanes.
- R7: In read mode, a read made while `busy_i` is low completes without stalling, even when too few bytes are present, under the same zero-fill rule.
- R8: In polling mode, `poll_cap_i` loads `poll_data_i` into the register. A host read returns that value with ready high and leaves the FIFO level unchanged.
- R9: `fl_push_ready_o` is high only in read mode with the FIFO not full. `fl_pop_valid_o` is high only in write mode with the FIFO not empty.
- R10: A host access that does not fit the mode completes at once and has no effect: a write in read or polling mode, or a read in write mode. A read in write mode returns zero.
- R11: `fifo_level_o` reports the number of stored bytes and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 0 write, 1 read, 2 polling, 3 idle |
| host_valid_i | input | 1 | Host access request |
| host_write_i | input | 1 | 1 = write, 0 = read |
| host_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_wdata_i | input | 32 | Write data, bottom-aligned |
| host_ready_o | output | 1 | Access completes this cycle |
| host_rdata_o | output | 32 | Read data, valid with ready |
| fl_push_valid_i | input | 1 | Flash engine offers a received byte |
| fl_push_data_i | input | 8 | Received byte |
| fl_push_ready_o | output | 1 | Received byte accepted |
| fl_pop_valid_o | output | 1 | Byte available for transmission |
| fl_pop_data_o | output | 8 | Oldest FIFO byte |
| fl_pop_ready_i | input | 1 | Flash engine takes the byte |
| busy_i | input | 1 | Transfer in progress |
| xfer_done_i | input | 1 | Transfer finished |
| poll_cap_i | input | 1 | Capture strobe for polled status |
| poll_data_i | input | 32 | Polled status value |
| fifo_level_o | output | 6 | Bytes held in the FIFO |

## Verification
Writes of each size are mixed in one FIFO. This shows whether the byte count and the little-endian lane order hold across size changes, because a wrong count shifts every later byte out of order. Reads are tried in three cases: with enough bytes present, with too few bytes and busy high where the fill arrives later, and with too few bytes where the transfer-done strobe arrives first. A fourth case has too few bytes with busy low. Together these separate a full return, a late-filled return, a zero-filled early completion and an immediate short return. Accesses that do not match the mode, and polling reads made while bytes sit in the FIFO, show whether anything touches the FIFO when it should not.

// File: rtl/fdp_pkg.sv
// Shared encodings for the flash data register port.
package fdp_pkg;
    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_READ  = 2'd1,
        MODE_POLL  = 2'd2,
        MODE_IDLE  = 2'd3
    } fdp_mode_e;

    localparam int LANES = 4;

    // Byte count of an access for a given size code (2 and 3 both mean a word).
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/fdp_byte_fifo.sv
// Byte FIFO that takes up to LANES bytes in and gives up to LANES bytes out
// per cycle. The caller must keep push_cnt within the free space and pop_cnt
// within the level. DEPTH must be a power of two.
module fdp_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1),
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        push_cnt,
    input  logic [LANES*8-1:0]   push_data,
    input  logic [CW-1:0]        pop_cnt,
    output logic [LANES*8-1:0]   head_data,
    output logic [LW-1:0]        level
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Write the pushed lanes at consecutive slots from the write pointer.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (CW'(i) < push_cnt) begin
                mem[wr_ptr + AW'(i)] <= push_data[i*8 +: 8];
            end
        end
    end

    // Advance both pointers and the level counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_cnt);
            rd_ptr <= rd_ptr + AW'(pop_cnt);
            level  <= level + LW'(push_cnt) - LW'(pop_cnt);
        end
    end

    // Show the oldest LANES bytes, oldest in lane 0.
    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head_data[g*8 +: 8] = mem[rd_ptr + AW'(g)];
    end
endmodule

// File: rtl/fdp_poll_reg.sv
// Holds the last polled status word. It loads only in polling mode and
// resets to zero.
module fdp_poll_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q
);
    // Capture the status word on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= din;
    end
endmodule

// File: rtl/fdp_host_ctrl.sv
// Host-side handshake and lane packing. This logic is combinational. It
// decides when an access may complete, how many bytes it moves, and what
// data it returns. It assumes the host holds its request stable while stalled.
module fdp_host_ctrl
    import fdp_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int CW = $clog2(LANES + 1)
) (
    input  fdp_mode_e           mode,
    input  logic                valid,
    input  logic                write,
    input  logic [1:0]          size,
    input  logic [31:0]         wdata,
    input  logic [LW-1:0]       level,
    input  logic                busy,
    input  logic                done,
    input  logic [LANES*8-1:0]  head_data,
    input  logic [31:0]         poll_value,
    output logic                ready,
    output logic [31:0]         rdata,
    output logic [CW-1:0]       push_cnt,
    output logic [31:0]         push_data,
    output logic [CW-1:0]       pop_cnt
);
    logic [2:0]    need;
    logic [LW-1:0] free_bytes;
    logic          enough;
    logic [2:0]    avail;
    logic          wr_fit;
    logic          rd_fit;

    // Work out the size and the FIFO occupancy seen by this access.
    always_comb begin
        need       = size_bytes(size);
        free_bytes = LW'(DEPTH) - level;
        enough     = level >= LW'(need);
        avail      = enough ? need : level[2:0];
        wr_fit     = free_bytes >= LW'(need);
        rd_fit     = enough || !busy || done;
    end

    // Handshake: stall only accesses that fit the mode and cannot be served.
    always_comb begin
        ready = 1'b1;
        if (mode == MODE_WRITE && write)      ready = wr_fit;
        else if (mode == MODE_READ && !write) ready = rd_fit;
    end

    // Byte movement for an accepted access.
    always_comb begin
        push_cnt  = '0;
        pop_cnt   = '0;
        push_data = wdata;
        if (valid && ready) begin
            if (mode == MODE_WRITE && write)      push_cnt = CW'(need);
            else if (mode == MODE_READ && !write) pop_cnt  = CW'(avail);
        end
    end

    // Return data: packed FIFO bytes, the polled word, or zero.
    always_comb begin
        rdata = '0;
        if (!write) begin
            if (mode == MODE_POLL) begin
                rdata = poll_value;
            end else if (mode == MODE_READ) begin
                for (int i = 0; i < LANES; i++) begin
                    if (3'(i) < avail) rdata[i*8 +: 8] = head_data[i*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/flash_data_port.sv
// Top level of the data register port. It connects the host control, the
// byte FIFO and the polled register, and routes the flash-side byte ports:
// the flash engine pushes in read mode and pops in write mode, so only one
// side pushes and only one side pops in any cycle.
module flash_data_port
    import fdp_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          host_valid_i,
    input  logic          host_write_i,
    input  logic [1:0]    host_size_i,
    input  logic [31:0]   host_wdata_i,
    output logic          host_ready_o,
    output logic [31:0]   host_rdata_o,
    input  logic          fl_push_valid_i,
    input  logic [7:0]    fl_push_data_i,
    output logic          fl_push_ready_o,
    output logic          fl_pop_valid_o,
    output logic [7:0]    fl_pop_data_o,
    input  logic          fl_pop_ready_i,
    input  logic          busy_i,
    input  logic          xfer_done_i,
    input  logic          poll_cap_i,
    input  logic [31:0]   poll_data_i,
    output logic [LW-1:0] fifo_level_o
);
    fdp_mode_e          mode;
    logic [LW-1:0]      level;
    logic [LANES*8-1:0] head;
    logic [31:0]        poll_q;
    logic [CW-1:0]      h_push_cnt;
    logic [CW-1:0]      h_pop_cnt;
    logic [31:0]        h_push_data;
    logic [CW-1:0]      f_push_cnt;
    logic [CW-1:0]      f_pop_cnt;
    logic [LANES*8-1:0] f_push_data;

    assign mode = fdp_mode_e'(mode_i);

    // Flash-side flow control, gated by mode and FIFO occupancy.
    always_comb begin
        fl_push_ready_o = (mode == MODE_READ)  && (level != LW'(DEPTH));
        fl_pop_valid_o  = (mode == MODE_WRITE) && (level != '0);
        fl_pop_data_o   = head[7:0];
    end

    // Pick the pushing and popping side for the current mode.
    always_comb begin
        if (mode == MODE_READ) begin
            f_push_cnt  = CW'(fl_push_valid_i && fl_push_ready_o);
            f_push_data = {{(LANES-1)*8{1'b0}}, fl_push_data_i};
            f_pop_cnt   = h_pop_cnt;
        end else begin
            f_push_cnt  = h_push_cnt;
            f_push_data = h_push_data;
            f_pop_cnt   = CW'(fl_pop_valid_o && fl_pop_ready_i);
        end
    end

    fdp_host_ctrl #(.DEPTH(DEPTH)) u_host (
        .mode       (mode),
        .valid      (host_valid_i),
        .write      (host_write_i),
        .size       (host_size_i),
        .wdata      (host_wdata_i),
        .level      (level),
        .busy       (busy_i),
        .done       (xfer_done_i),
        .head_data  (head),
        .poll_value (poll_q),
        .ready      (host_ready_o),
        .rdata      (host_rdata_o),
        .push_cnt   (h_push_cnt),
        .push_data  (h_push_data),
        .pop_cnt    (h_pop_cnt)
    );

    fdp_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_cnt  (f_push_cnt),
        .push_data (f_push_data),
        .pop_cnt   (f_pop_cnt),
        .head_data (head),
        .level     (level)
    );

    fdp_poll_reg #(.DW(32)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (poll_cap_i && mode == MODE_POLL),
        .din   (poll_data_i),
        .q     (poll_q)
    );

    assign fifo_level_o = level;
endmodule

// File: rtl/fdp_chk.sv
// Protocol checker for flash_data_port, bound to every instance. It watches
// only the ports.
module fdp_chk #(
    parameter int DEPTH = 32,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic          host_valid_i,
    input logic          host_write_i,
    input logic [1:0]    host_size_i,
    input logic          host_ready_o,
    input logic          fl_push_valid_i,
    input logic          fl_push_ready_o,
    input logic          fl_pop_valid_o,
    input logic          fl_pop_ready_i,
    input logic          busy_i,
    input logic          xfer_done_i,
    input logic [LW-1:0] fifo_level_o
);
    logic [LW-1:0] need;
    assign need = (host_size_i == 2'd0) ? LW'(1) : (host_size_i == 2'd1) ? LW'(2) : LW'(4);

    // R11
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level_o <= LW'(DEPTH));

    // R9
    push_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_push_ready_o |-> (mode_i == 2'd1 && fifo_level_o != LW'(DEPTH)));

    // R9
    pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_pop_valid_o |-> (mode_i == 2'd0 && fifo_level_o != '0));

    // R8
    poll_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd2) |=> (fifo_level_o == $past(fifo_level_o)));

    // R5
    read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && host_valid_i && !host_write_i && busy_i && !xfer_done_i
         && fifo_level_o < need) |-> !host_ready_o);

    // R3
    write_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && host_valid_i && host_write_i && host_ready_o)
        |-> (fifo_level_o + need <= LW'(DEPTH)));

    // R4
    read_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && host_valid_i && !host_write_i && host_ready_o
         && fifo_level_o >= need && !fl_push_valid_i)
        |=> (fifo_level_o == $past(fifo_level_o) - $past(need)));

    // R10
    write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && host_valid_i && host_write_i && !fl_push_valid_i)
        |=> (fifo_level_o == $past(fifo_level_o)));

    // R2
    write_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && host_valid_i && host_write_i && host_ready_o && !fl_pop_ready_i)
        |=> (fifo_level_o == $past(fifo_level_o) + $past(need)));
endmodule

bind flash_data_port fdp_chk #(.DEPTH(DEPTH)) u_fdp_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_i          (mode_i),
    .host_valid_i    (host_valid_i),
    .host_write_i    (host_write_i),
    .host_size_i     (host_size_i),
    .host_ready_o    (host_ready_o),
    .fl_push_valid_i (fl_push_valid_i),
    .fl_push_ready_o (fl_push_ready_o),
    .fl_pop_valid_o  (fl_pop_valid_o),
    .fl_pop_ready_i  (fl_pop_ready_i),
    .busy_i          (busy_i),
    .xfer_done_i     (xfer_done_i),
    .fifo_level_o    (fifo_level_o)
);

// File: tb/test_flash_data_port.sv
// Scoreboard bench. Write tasks queue the bytes they expect, and a monitor
// compares every byte the flash side drains.
module test_flash_data_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        host_valid_i = 1'b0;
    logic        host_write_i = 1'b0;
    logic [1:0]  host_size_i = 2'd0;
    logic [31:0] host_wdata_i = '0;
    logic        host_ready_o;
    logic [31:0] host_rdata_o;
    logic        fl_push_valid_i = 1'b0;
    logic [7:0]  fl_push_data_i = '0;
    logic        fl_push_ready_o;
    logic        fl_pop_valid_o;
    logic [7:0]  fl_pop_data_o;
    logic        fl_pop_ready_i = 1'b0;
    logic        busy_i = 1'b0;
    logic        xfer_done_i = 1'b0;
    logic        poll_cap_i = 1'b0;
    logic [31:0] poll_data_i = '0;
    logic [5:0]  fifo_level_o;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    flash_data_port i_flash_data_port (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each drained byte with the scoreboard (R2).
    always @(negedge clk) begin
        if (rst_n && fl_pop_valid_o && fl_pop_ready_i) begin
            if (exp_q.size() == 0) check(1'b0, "R2 unexpected byte", {24'd0, fl_pop_data_o}, 32'd0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(fl_pop_data_o == e, "R2 drain order", {24'd0, fl_pop_data_o}, {24'd0, e});
            end
        end
    end

    // Host access. Called just after a rising edge; returns just after one.
    task automatic host_acc(input bit wr, input logic [1:0] sz, input logic [31:0] wd,
                            output logic [31:0] rd, output int stalls);
        host_valid_i = 1'b1; host_write_i = wr; host_size_i = sz; host_wdata_i = wd;
        stalls = 0;
        forever begin
            @(negedge clk);
            if (host_ready_o) begin rd = host_rdata_o; break; end
            stalls++;
        end
        @(posedge clk); #1;
        host_valid_i = 1'b0;
    endtask

    // Driver for writes: queue the expected bytes, then make the access.
    task automatic host_write(input logic [1:0] sz, input logic [31:0] wd, output int stalls);
        logic [31:0] rd;
        int n;
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        for (int i = 0; i < n; i++) exp_q.push_back(wd[i*8 +: 8]);
        host_acc(1'b1, sz, wd, rd, stalls);
    endtask

    task automatic flash_push(input logic [7:0] b);
        fl_push_valid_i = 1'b1; fl_push_data_i = b;
        forever begin @(negedge clk); if (fl_push_ready_o) break; end
        @(posedge clk); #1;
        fl_push_valid_i = 1'b0;
    endtask

    task automatic drain();
        fl_pop_ready_i = 1'b1;
        while (fifo_level_o != 0) begin @(posedge clk); #1; end
        fl_pop_ready_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int st;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(fifo_level_o == 0, "R1 level", 32'(fifo_level_o), 0);
        check(!fl_pop_valid_o, "R1 pop valid", 32'(fl_pop_valid_o), 0);
        @(posedge clk); #1;
        mode_i = 2'd2;
        host_acc(1'b0, 2'd2, 0, rd, st);
        check(rd == 0, "R1 poll reset value", rd, 0);

        // R2 mixed sizes
        mode_i = 2'd0;
        host_write(2'd0, 32'hDEADBE11, st);
        host_write(2'd1, 32'hFFFF2233, st);
        host_write(2'd2, 32'h44556677, st);
        @(negedge clk);
        check(fifo_level_o == 7, "R2 R11 level after 1+2+4", 32'(fifo_level_o), 7);
        @(posedge clk); #1;
        drain();
        @(negedge clk);
        check(!fl_pop_valid_o, "R9 pop valid when empty", 32'(fl_pop_valid_o), 0);
        @(posedge clk); #1;

        // R3 write stall on full FIFO
        for (int i = 0; i < 8; i++) host_write(2'd2, 32'h01020304 + 32'(i) * 32'h10101010, st);
        @(negedge clk);
        check(fifo_level_o == 32, "R11 full level", 32'(fifo_level_o), 32);
        @(posedge clk); #1;
        fork
            host_write(2'd2, 32'hA1B2C3D4, st);
            begin
                repeat (5) @(posedge clk); #1;
                fl_pop_ready_i = 1'b1;
                repeat (4) @(posedge clk); #1;
                fl_pop_ready_i = 1'b0;
            end
        join
        check(st >= 5, "R3 write stalled until space", 32'(st), 5);
        drain();
        check(exp_q.size() == 0, "R2 scoreboard empty", 32'(exp_q.size()), 0);

        // R4 reads of each size
        mode_i = 2'd1;
        for (int i = 0; i < 8; i++) flash_push(8'hA0 + 8'(i));
        host_acc(1'b0, 2'd0, 0, rd, st);
        check(rd == 32'h000000A0, "R4 byte read", rd, 32'h000000A0);
        host_acc(1'b0, 2'd1, 0, rd, st);
        check(rd == 32'h0000A2A1, "R4 halfword read", rd, 32'h0000A2A1);
        host_acc(1'b0, 2'd2, 0, rd, st);
        check(rd == 32'hA6A5A4A3, "R4 word read", rd, 32'hA6A5A4A3);
        @(negedge clk);
        check(fifo_level_o == 1, "R4 level after pops", 32'(fifo_level_o), 1);
        @(posedge clk); #1;

        // R5 busy stall, filled later
        busy_i = 1'b1;
        fork
            host_acc(1'b0, 2'd2, 0, rd, st);
            begin
                repeat (3) @(posedge clk); #1;
                flash_push(8'hB0); flash_push(8'hB1); flash_push(8'hB2);
            end
        join
        check(rd == 32'hB2B1B0A7, "R5 late-filled word", rd, 32'hB2B1B0A7);
        check(st > 0, "R5 read stalled", 32'(st), 1);

        // R6 done ends the stall with zero fill
        flash_push(8'hC0);
        fork
            host_acc(1'b0, 2'd2, 0, rd, st);
            begin
                repeat (4) @(posedge clk); #1;
                xfer_done_i = 1'b1;
                @(posedge clk); #1;
                xfer_done_i = 1'b0;
            end
        join
        check(rd == 32'h000000C0, "R6 zero-filled on done", rd, 32'h000000C0);
        check(st >= 3, "R6 stalled before done", 32'(st), 3);
        @(negedge clk);
        check(fifo_level_o == 0, "R6 popped only present", 32'(fifo_level_o), 0);
        @(posedge clk); #1;
        busy_i = 1'b0;

        // R7 not busy, short read immediately
        flash_push(8'hD0); flash_push(8'hD1);
        host_acc(1'b0, 2'd2, 0, rd, st);
        check(rd == 32'h0000D1D0 && st == 0, "R7 immediate short read", rd, 32'h0000D1D0);

        // R10 mismatched accesses
        flash_push(8'hE0);
        host_acc(1'b1, 2'd2, 32'h12345678, rd, st);
        @(negedge clk);
        check(fifo_level_o == 1 && st == 0, "R10 write in read mode ignored", 32'(fifo_level_o), 1);
        @(posedge clk); #1;
        mode_i = 2'd0;
        host_acc(1'b0, 2'd2, 0, rd, st);
        check(rd == 0, "R10 read in write mode returns zero", rd, 0);
        @(negedge clk);
        check(fifo_level_o == 1, "R10 read in write mode no pop", 32'(fifo_level_o), 1);
        check(!fl_push_ready_o, "R9 no push in write mode", 32'(fl_push_ready_o), 0);
        @(posedge clk); #1;
        exp_q.push_back(8'hE0);
        drain();

        // R8 polling
        mode_i = 2'd1;
        flash_push(8'hF0);
        mode_i = 2'd2;
        poll_data_i = 32'hCAFE1234; poll_cap_i = 1'b1;
        @(posedge clk); #1;
        poll_cap_i = 1'b0; poll_data_i = 32'h0;
        host_acc(1'b0, 2'd0, 0, rd, st);
        check(rd == 32'hCAFE1234 && st == 0, "R8 poll value unmasked", rd, 32'hCAFE1234);
        host_acc(1'b1, 2'd2, 32'h55555555, rd, st);
        @(negedge clk);
        check(fifo_level_o == 1, "R8 R10 poll leaves FIFO", 32'(fifo_level_o), 1);
        check(!fl_push_ready_o && !fl_pop_valid_o, "R9 flash ports idle in poll", 32'({fl_push_ready_o, fl_pop_valid_o}), 0);
        check(exp_q.size() == 0, "R2 all bytes drained", 32'(exp_q.size()), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule